// File: doc/BRIEF.md
# Task-File Hidden Configuration Bank Unlock Sequencer

This block sits on the device side of an ATA task-file register port. It watches every host access for an ordered, width-sensitive key pattern. Once the pattern completes, the same task-file offsets stop reaching the normal registers and instead reach a small hidden bank of controller configuration bytes. A single restore write returns the port to normal operation.

The host unlocks the bank in three steps. It issues two 16-bit reads of offset 1, then an 8-bit write of 0x03 to offset 2. While the bank is selected, reads are served from the configuration bytes. Writes land there and are not passed on to the normal registers. The normal register file lives outside this block; its read data comes in on a port and its strobes go out gated.

Top module: `tf_cfg_unlock`

## Requirements
- R1: After a synchronous active-low reset, `cfg_sel` is 0, the detector is idle and every configuration byte reads as 0 once the bank is next opened.
- R2: Two 16-bit reads of offset 1 followed by an 8-bit write whose low byte is 0x03 to offset 2 set `cfg_sel` from the next cycle. Idle cycles with no strobe may separate these steps. Further 16-bit reads of offset 1 after the second one keep the detector armed.
- R3: Any other access before the key write sends the detector back to idle, so the key write has no effect. This includes an 8-bit read of offset 1, a read of another offset, a key write with a different value, and a 16-bit write to offset 2.
- R4: The key reads and the key write go to the normal bank: reads return `nrm_rdata`, and the strobes appear on `nrm_rd` and `nrm_wr`.
- R5: With the bank selected, offsets 0, 1, 3, 5 and 6 each hold one byte. A write stores `tf_wdata[7:0]` at the next edge. A read returns the byte in bits [7:0] with bits [15:8] at 0.
- R6: With the bank selected, offsets 2, 4 and 7 read as 0 and ignore writes.
- R7: With the bank selected, `nrm_rd` and `nrm_wr` stay low. Otherwise they follow `tf_rd` and `tf_wr`.
- R8: With the bank selected, an 8-bit write of 0x83 to offset 2 clears `cfg_sel` from the next cycle. Other values, and 16-bit writes, at that offset leave it set. Stored bytes survive leaving and re-entering the bank.
- R9: Reads never change `cfg_sel`.
- R10: While the bank is selected, the key pattern is not detected. After restore, a lone key write does not reopen the bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tf_offset | input | 3 | Task-file register offset of the access |
| tf_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| tf_rd | input | 1 | Read strobe, one cycle per access |
| tf_wr | input | 1 | Write strobe, one cycle per access |
| tf_wdata | input | 16 | Write data |
| nrm_rdata | input | 16 | Read data from the normal task-file registers |
| nrm_rd | output | 1 | Read strobe passed to the normal registers |
| nrm_wr | output | 1 | Write strobe passed to the normal registers |
| cfg_sel | output | 1 | 1 while the hidden configuration bank is selected |
| rd_data | output | 16 | Routed read data |

## Verification
Two things coincide on the closing key write: it must reach the normal registers as an ordinary write, and it must flip the bank select for the very next access. The bench issues that write and reads configuration offset 0 in the following cycle. It expects `nrm_wr` high on the write and configuration data, not `nrm_rdata`, on the read. The restore write is probed the same way in reverse: that write must be kept from the normal bank, and the next read must return normal data.

// File: rtl/tf_cfg_pkg.sv
// Package: shared types and default geometry for the task-file
// configuration-bank unlock sequencer.
package tf_cfg_pkg;

    // Key detector states: idle, one key read seen, two or more seen.
    typedef enum logic [1:0] {
        DET_IDLE = 2'd0,
        DET_ONE  = 2'd1,
        DET_TWO  = 2'd2
    } det_state_t;

    localparam int TF_OFF_W  = 3;
    localparam int TF_DATA_W = 16;
    localparam int CFG_W     = 8;

    // Implemented configuration offsets: 0, 1, 3, 5, 6.
    localparam logic [7:0] CFG_IMPL_DEFAULT = 8'b0110_1011;

endpackage

// File: rtl/tf_seq_detect.sv
// Module: tf_seq_detect
// Watches task-file accesses for the key pattern and owns the bank-select
// flag. Assumes at most one of rd/wr per cycle, and one cycle per access.
// Idle cycles do not disturb the detector.
module tf_seq_detect
    import tf_cfg_pkg::*;
#(
    parameter int         OFF_W     = TF_OFF_W,
    parameter int         BYTE_W    = CFG_W,
    parameter int         KEY_RD    = 1,
    parameter int         KEY_WR    = 2,
    parameter logic [7:0] KEY_OPEN  = 8'h03,
    parameter logic [7:0] KEY_CLOSE = 8'h83
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFF_W-1:0]  offset,
    input  logic              wide,
    input  logic              rd,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wbyte,
    output logic              cfg_sel
);

    localparam logic [OFF_W-1:0] KRD = OFF_W'(KEY_RD);
    localparam logic [OFF_W-1:0] KWR = OFF_W'(KEY_WR);

    det_state_t state_q, state_d;
    logic       sel_d;
    logic       any_acc, is_key_rd, is_open, is_close;

    // Classify the current access against the key pattern.
    always_comb begin
        any_acc   = rd | wr;
        is_key_rd = rd && wide && (offset == KRD);
        is_open   = wr && !wide && (offset == KWR) && (wbyte == KEY_OPEN[BYTE_W-1:0]);
        is_close  = wr && !wide && (offset == KWR) && (wbyte == KEY_CLOSE[BYTE_W-1:0]);
    end

    // Next-state logic for the detector and the bank flag.
    always_comb begin
        state_d = state_q;
        sel_d   = cfg_sel;
        if (cfg_sel) begin
            state_d = DET_IDLE;
            if (is_close) sel_d = 1'b0;
        end else if (any_acc) begin
            unique case (state_q)
                DET_IDLE: state_d = is_key_rd ? DET_ONE : DET_IDLE;
                DET_ONE:  state_d = is_key_rd ? DET_TWO : DET_IDLE;
                DET_TWO: begin
                    if (is_open) begin
                        sel_d   = 1'b1;
                        state_d = DET_IDLE;
                    end else begin
                        state_d = is_key_rd ? DET_TWO : DET_IDLE;
                    end
                end
                default: state_d = DET_IDLE;
            endcase
        end
    end

    // State registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DET_IDLE;
            cfg_sel <= 1'b0;
        end else begin
            state_q <= state_d;
            cfg_sel <= sel_d;
        end
    end

endmodule

// File: rtl/tf_cfg_bank.sv
// Module: tf_cfg_bank
// Hidden byte-wide configuration storage. One register per offset whose
// IMPL_MASK bit is set; other offsets read zero and drop writes.
// Writes are accepted only while en (bank selected) is high.
module tf_cfg_bank #(
    parameter int                    OFF_W     = 3,
    parameter int                    BYTE_W    = 8,
    parameter int                    DATA_W    = 16,
    parameter logic [(1<<OFF_W)-1:0] IMPL_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [OFF_W-1:0]  offset,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wbyte,
    output logic [DATA_W-1:0] rdata
);

    localparam int NREG = 1 << OFF_W;

    logic [BYTE_W-1:0] regs [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_slot
        if (IMPL_MASK[i]) begin : g_reg
            // Store the low write byte when this slot is addressed.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs[i] <= '0;
                else if (en && wr && (offset == OFF_W'(i)))
                    regs[i] <= wbyte;
            end
        end else begin : g_hole
            assign regs[i] = '0;
        end
    end

    // Zero-extend the addressed byte onto the read bus.
    always_comb begin
        rdata = DATA_W'(regs[offset]);
    end

endmodule

// File: rtl/tf_bank_route.sv
// Module: tf_bank_route
// Steers strobes and read data between the normal task-file registers
// and the hidden configuration bank according to the bank flag.
module tf_bank_route #(
    parameter int DATA_W = 16
) (
    input  logic              cfg_sel,
    input  logic              rd,
    input  logic              wr,
    input  logic [DATA_W-1:0] nrm_rdata,
    input  logic [DATA_W-1:0] cfg_rdata,
    output logic              nrm_rd,
    output logic              nrm_wr,
    output logic [DATA_W-1:0] rd_data
);

    // Gate normal-bank strobes and pick the read source.
    always_comb begin
        nrm_rd  = rd & ~cfg_sel;
        nrm_wr  = wr & ~cfg_sel;
        rd_data = cfg_sel ? cfg_rdata : nrm_rdata;
    end

endmodule

// File: rtl/tf_cfg_unlock.sv
// Module: tf_cfg_unlock (top)
// Task-file port front end that opens a hidden configuration bank after
// a key access pattern and closes it on a restore write. Assumes
// single-cycle strobes, never rd and wr together, synchronous reset.
module tf_cfg_unlock
    import tf_cfg_pkg::*;
#(
    parameter int                       OFF_W     = TF_OFF_W,
    parameter int                       DATA_W    = TF_DATA_W,
    parameter int                       BYTE_W    = CFG_W,
    parameter logic [(1<<OFF_W)-1:0]    IMPL_MASK = CFG_IMPL_DEFAULT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFF_W-1:0]  tf_offset,
    input  logic              tf_wide,
    input  logic              tf_rd,
    input  logic              tf_wr,
    input  logic [DATA_W-1:0] tf_wdata,
    input  logic [DATA_W-1:0] nrm_rdata,
    output logic              nrm_rd,
    output logic              nrm_wr,
    output logic              cfg_sel,
    output logic [DATA_W-1:0] rd_data
);

    logic [BYTE_W-1:0]        wbyte;
    logic [DATA_W-1:0]        cfg_rdata;
    logic [DATA_W-BYTE_W-1:0] unused_wdata_hi;

    assign wbyte           = tf_wdata[BYTE_W-1:0];
    assign unused_wdata_hi = tf_wdata[DATA_W-1:BYTE_W];

    tf_seq_detect #(
        .OFF_W  (OFF_W),
        .BYTE_W (BYTE_W)
    ) u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .offset  (tf_offset),
        .wide    (tf_wide),
        .rd      (tf_rd),
        .wr      (tf_wr),
        .wbyte   (wbyte),
        .cfg_sel (cfg_sel)
    );

    tf_cfg_bank #(
        .OFF_W     (OFF_W),
        .BYTE_W    (BYTE_W),
        .DATA_W    (DATA_W),
        .IMPL_MASK (IMPL_MASK)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (cfg_sel),
        .offset (tf_offset),
        .wr     (tf_wr),
        .wbyte  (wbyte),
        .rdata  (cfg_rdata)
    );

    tf_bank_route #(
        .DATA_W (DATA_W)
    ) u_route (
        .cfg_sel   (cfg_sel),
        .rd        (tf_rd),
        .wr        (tf_wr),
        .nrm_rdata (nrm_rdata),
        .cfg_rdata (cfg_rdata),
        .nrm_rd    (nrm_rd),
        .nrm_wr    (nrm_wr),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/tf_cfg_unlock_chk.sv
// Module: tf_cfg_unlock_chk
// Property checker for tf_cfg_unlock, attached with bind below.
module tf_cfg_unlock_chk #(
    parameter int                    OFF_W     = 3,
    parameter int                    DATA_W    = 16,
    parameter logic [(1<<OFF_W)-1:0] IMPL_MASK = '1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [OFF_W-1:0]  tf_offset,
    input logic              tf_wide,
    input logic              tf_rd,
    input logic              tf_wr,
    input logic [DATA_W-1:0] tf_wdata,
    input logic              cfg_sel,
    input logic [DATA_W-1:0] rd_data
);

    // R2: the bank opens only right after an 8-bit 0x03 write to offset 2.
    assert_open_by_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_sel) |-> $past(tf_wr && !tf_wide && tf_offset == OFF_W'(2)
                                 && tf_wdata[7:0] == 8'h03));

    // R8: the bank closes only right after an 8-bit 0x83 write to offset 2.
    assert_close_by_restore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_sel) |-> $past(tf_wr && !tf_wide && tf_offset == OFF_W'(2)
                                 && tf_wdata[7:0] == 8'h83));

    // R9: a cycle without a write leaves the bank flag unchanged.
    assert_no_write_keeps_bank_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !tf_wr |=> $stable(cfg_sel));

    // R6: unimplemented configuration offsets read zero.
    assert_hole_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel && tf_rd && !IMPL_MASK[tf_offset]) |-> rd_data == '0);

    // R5: configuration reads never drive the upper byte.
    assert_cfg_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel && tf_rd) |-> rd_data[DATA_W-1:8] == '0);

endmodule

bind tf_cfg_unlock tf_cfg_unlock_chk #(
    .OFF_W     (OFF_W),
    .DATA_W    (DATA_W),
    .IMPL_MASK (IMPL_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tf_offset (tf_offset),
    .tf_wide   (tf_wide),
    .tf_rd     (tf_rd),
    .tf_wr     (tf_wr),
    .tf_wdata  (tf_wdata),
    .cfg_sel   (cfg_sel),
    .rd_data   (rd_data)
);

// File: tb/tf_cfg_unlock_test.sv
`timescale 1ns/1ps
// Scoreboard bench: step() drives one cycle and queues its expectations;
// the monitor pops and compares them at the falling edge of that cycle.
module tf_cfg_unlock_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  tf_offset = '0;
    logic        tf_wide = 1'b0;
    logic        tf_rd = 1'b0;
    logic        tf_wr = 1'b0;
    logic [15:0] tf_wdata = '0;
    logic [15:0] nrm_rdata;
    logic        nrm_rd, nrm_wr, cfg_sel;
    logic [15:0] rd_data;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic  esel;
        logic  enrd;
        logic  enwr;
        int    erd;
        string tag;
    } exp_t;

    exp_t q[$];

    always #2.5 clk = ~clk;

    // Normal bank model: upper byte A5, low byte the offset.
    assign nrm_rdata = {8'hA5, 5'b0, tf_offset};

    tf_cfg_unlock uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tf_offset (tf_offset),
        .tf_wide   (tf_wide),
        .tf_rd     (tf_rd),
        .tf_wr     (tf_wr),
        .tf_wdata  (tf_wdata),
        .nrm_rdata (nrm_rdata),
        .nrm_rd    (nrm_rd),
        .nrm_wr    (nrm_wr),
        .cfg_sel   (cfg_sel),
        .rd_data   (rd_data)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Monitor: compare the queued expectation for this cycle.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(cfg_sel === e.esel, e.tag, "cfg_sel", int'(cfg_sel), int'(e.esel));
            check(nrm_wr === e.enwr, e.tag, "nrm_wr", int'(nrm_wr), int'(e.enwr));
            check(nrm_rd === e.enrd, e.tag, "nrm_rd", int'(nrm_rd), int'(e.enrd));
            if (e.erd >= 0)
                check(rd_data === 16'(e.erd), e.tag, "rd_data", int'(rd_data), e.erd);
        end
    end

    // Driver: one access (or idle) per cycle; esel is the bank during it.
    task automatic step(input logic [2:0] off, input logic wide, input logic rd,
                        input logic wr, input logic [15:0] wd, input logic esel,
                        input int erd, input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        tf_offset = off; tf_wide = wide; tf_rd = rd; tf_wr = wr; tf_wdata = wd;
        e.esel = esel;
        e.enrd = rd & ~esel;   // R7
        e.enwr = wr & ~esel;   // R7
        e.erd  = rd ? erd : -1;
        e.tag  = tag;
        q.push_back(e);
    endtask

    task automatic idle(input logic esel, input string tag);
        step(3'd0, 1'b0, 1'b0, 1'b0, 16'h0, esel, -1, tag);
    endtask
    task automatic rd16(input logic [2:0] off, input logic esel, input int erd, input string tag);
        step(off, 1'b1, 1'b1, 1'b0, 16'h0, esel, erd, tag);
    endtask
    task automatic rd8(input logic [2:0] off, input logic esel, input int erd, input string tag);
        step(off, 1'b0, 1'b1, 1'b0, 16'h0, esel, erd, tag);
    endtask
    task automatic wr8(input logic [2:0] off, input logic [7:0] v, input logic esel, input string tag);
        step(off, 1'b0, 1'b0, 1'b1, {8'h00, v}, esel, -1, tag);
    endtask
    task automatic wr16(input logic [2:0] off, input logic [15:0] v, input logic esel, input string tag);
        step(off, 1'b1, 1'b0, 1'b1, v, esel, -1, tag);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Watchdog: an expired run counts as one failed check.
    initial begin
        #250000;
        total++;
        bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        idle(1'b0, "R1");

        // R2 / R4: key reads return normal data, key write reaches normal bank.
        rd16(3'd1, 1'b0, 16'hA501, "R4_key_rd");
        rd16(3'd1, 1'b0, 16'hA501, "R4_key_rd");
        wr8(3'd2, 8'h03, 1'b0, "R4_key_wr");
        // Bank switches for the very next access; bytes start at zero.
        rd8(3'd0, 1'b1, 16'h0000, "R1_zero_cfg");
        wr8(3'd0, 8'h5A, 1'b1, "R7_gated");
        wr8(3'd1, 8'h3C, 1'b1, "R5");
        wr8(3'd3, 8'h95, 1'b1, "R5");
        wr8(3'd5, 8'h01, 1'b1, "R5");
        wr16(3'd6, 16'hFF7F, 1'b1, "R5_low_byte");
        // R6: holes drop writes and read zero.
        wr8(3'd4, 8'hEE, 1'b1, "R6");
        wr8(3'd7, 8'hDD, 1'b1, "R6");
        rd8(3'd4, 1'b1, 16'h0000, "R6");
        rd16(3'd7, 1'b1, 16'h0000, "R6");
        rd8(3'd2, 1'b1, 16'h0000, "R6");
        // R5: stored bytes read back zero-extended.
        rd8(3'd0, 1'b1, 16'h005A, "R5");
        rd16(3'd1, 1'b1, 16'h003C, "R5");
        rd8(3'd3, 1'b1, 16'h0095, "R5");
        rd8(3'd5, 1'b1, 16'h0001, "R5");
        rd16(3'd6, 1'b1, 16'h007F, "R5");
        // R10: key pattern inside the bank does nothing.
        rd16(3'd1, 1'b1, 16'h003C, "R10");
        rd16(3'd1, 1'b1, 16'h003C, "R10");
        wr8(3'd2, 8'h03, 1'b1, "R10");
        idle(1'b1, "R10");
        // R8: wrong value and 16-bit restore keep the bank.
        wr8(3'd2, 8'h84, 1'b1, "R8_other");
        wr16(3'd2, 16'h0083, 1'b1, "R8_wide");
        idle(1'b1, "R8_kept");
        wr8(3'd2, 8'h83, 1'b1, "R8_restore");
        rd16(3'd0, 1'b0, 16'hA500, "R8_normal");
        // R10: lone key write after restore does not reopen.
        wr8(3'd2, 8'h03, 1'b0, "R10_lone");
        idle(1'b0, "R10_lone");

        // R3: pattern breakers.
        rd16(3'd1, 1'b0, 16'hA501, "R3");
        rd8(3'd1, 1'b0, 16'hA501, "R3_rd8");
        rd16(3'd1, 1'b0, 16'hA501, "R3");
        wr8(3'd2, 8'h03, 1'b0, "R3_rd8");
        idle(1'b0, "R3_rd8");
        rd16(3'd1, 1'b0, 16'hA501, "R3");
        rd16(3'd1, 1'b0, 16'hA501, "R3");
        wr8(3'd2, 8'h04, 1'b0, "R3_value");
        wr8(3'd2, 8'h03, 1'b0, "R3_value");
        idle(1'b0, "R3_value");
        rd16(3'd1, 1'b0, 16'hA501, "R3");
        rd16(3'd1, 1'b0, 16'hA501, "R3");
        rd16(3'd3, 1'b0, 16'hA503, "R3_offset");
        wr8(3'd2, 8'h03, 1'b0, "R3_offset");
        idle(1'b0, "R3_offset");
        rd16(3'd1, 1'b0, 16'hA501, "R3");
        rd16(3'd1, 1'b0, 16'hA501, "R3");
        wr16(3'd2, 16'h0003, 1'b0, "R3_wide");
        idle(1'b0, "R3_wide");

        // R2: idle gaps allowed; R8: stored bytes retained.
        rd16(3'd1, 1'b0, 16'hA501, "R2_gap");
        idle(1'b0, "R2_gap");
        rd16(3'd1, 1'b0, 16'hA501, "R2_gap");
        idle(1'b0, "R2_gap");
        wr8(3'd2, 8'h03, 1'b0, "R2_gap");
        rd8(3'd0, 1'b1, 16'h005A, "R8_retain");
        rd8(3'd3, 1'b1, 16'h0095, "R9_read");
        idle(1'b1, "R9_read");

        // R1: reset inside the bank returns to normal and clears bytes.
        @(posedge clk);
        #1 rst_n = 1'b0;
        tf_rd = 1'b0; tf_wr = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        idle(1'b0, "R1_reset");
        // R2: a third key read keeps the detector armed.
        rd16(3'd1, 1'b0, 16'hA501, "R2_three");
        rd16(3'd1, 1'b0, 16'hA501, "R2_three");
        rd16(3'd1, 1'b0, 16'hA501, "R2_three");
        wr8(3'd2, 8'h03, 1'b0, "R2_three");
        rd8(3'd0, 1'b1, 16'h0000, "R1_cleared");
        wr8(3'd2, 8'h83, 1'b1, "R8");
        idle(1'b0, "R8");

        repeat (3) @(posedge clk);
        summary();
    end

endmodule